// File: doc/BRIEF.md
# Decode-Stage Equality Branch Resolver

This block decides branch-on-equal instructions while they sit in the decode stage of a five-stage pipeline, which makes the taken branch cost less. The branch in the IF/ID register names two source registers. Each source is read from a local register array. When the instruction now in the memory stage is an ALU operation that writes that register, the operand is taken from that instruction's result instead. The two resolved values are compared. On a match the block redirects fetch to the PC of the following instruction plus the sign-extended word offset.

Branches use one delay slot. The instruction fetched in the same cycle as the resolving branch always enters IF/ID, and only the fetch after it goes to the target. An operand may still be in flight, either from an ALU operation in execute or from a load in execute or memory. In that case the block stalls: the PC and IF/ID hold, and the branch is decided again in the next cycle. A small fetch model (PC register, IF/ID register) and the register array are included, so the block can be exercised alone. The caller supplies the instruction word for the current fetch address and describes the execute and memory stage occupants.

Top module: `decode_branch_unit`

## Requirements
- R1: While reset is high, after a clock edge, fetch_pc equals RESET_PC (0), ifid_instr is 0, and br_stall and br_taken are 0.
- R2: With no stall and no taken branch, each clock loads fetch_instr into ifid_instr, sets ifid_pc4 to the old fetch_pc plus 4 and advances fetch_pc by 4.
- R3: An instruction is a branch when bits [31:26] equal BR_OPC (default 4). Its sources are bits [25:21] (A) and [20:16] (B). br_taken is 1 exactly when it is a branch and the two resolved operands are equal. Other opcodes never assert br_taken.
- R4: br_target equals ifid_pc4 plus the sign-extended bits [15:0] shifted left by 2.
- R5: A source register is replaced by mem_result when mem_kind is ALU (1) and mem_dst equals that register.
- R6: A write port (wb_we, wb_addr, wb_data) updates the register array at the clock edge. A read of the register being written in the same cycle returns wb_data. Register 0 reads as zero and writes to it are ignored.
- R7: br_stall is 1 when the branch reads a register that is the destination of an ALU instruction in execute (ex_kind 1, ex_dst).
- R8: br_stall is 1 when the branch reads a register that is the destination of a load in execute (ex_kind 2).
- R9: br_stall is 1 when the branch reads a register that is the destination of a load in memory (mem_kind 2). Kinds 0 (none) and 3 (no destination) never stall or bypass.
- R10: A destination of register 0 never causes a stall or a bypass.
- R11: While br_stall is 1, fetch_pc and ifid_instr keep their values across the clock edge.
- R12: When br_taken is 1 and br_stall is 0, the instruction at the current fetch_pc (the delay slot) enters IF/ID, and fetch_pc becomes br_target.
- R13: When br_stall and br_taken are both 1, fetch_pc holds. After the stall clears, the same branch redirects fetch to its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | DATA_W | Address of the instruction being fetched |
| fetch_instr | input | 32 | Instruction word at fetch_pc |
| wb_we | input | 1 | Register write enable |
| wb_addr | input | 5 | Register write index |
| wb_data | input | DATA_W | Register write data |
| ex_kind | input | 2 | Execute-stage occupant: 0 none, 1 ALU, 2 load, 3 no destination |
| ex_dst | input | 5 | Execute-stage destination register |
| mem_kind | input | 2 | Memory-stage occupant, same encoding |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_result | input | DATA_W | ALU result held at the memory stage |
| ifid_instr | output | 32 | Instruction in decode |
| ifid_pc4 | output | DATA_W | Address of the decode instruction plus 4 |
| br_stall | output | 1 | Branch operand not yet available |
| br_taken | output | 1 | Branch operands compare equal |
| br_target | output | DATA_W | Branch destination address |

## Verification
The stall and the equality decision can be true in the same cycle. A branch whose operands already match may also read a register that an ALU operation in execute is about to overwrite. The bench provokes this by reset-releasing straight into such a branch with a matching execute destination. It then requires that the PC and IF/ID stay put while br_taken is high. Once the execute occupant is cleared, the delay slot must enter decode and fetch must land on the target. The full sweep also places a memory-stage bypass and a stall on the same branch, and compares each output against values computed arithmetically.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int INSN_W    = 32;
  localparam int OPC_W     = 6;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 16;
  localparam int OPC_LO    = 26;
  localparam int SRC_A_LO  = 21;
  localparam int SRC_B_LO  = 16;
  localparam int NUM_SRC   = 2;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_ALU   = 2'd1,
    KIND_LOAD  = 2'd2,
    KIND_NODST = 2'd3
  } stage_kind_e;

  typedef struct packed {
    logic [OPC_W-1:0]     opc;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    logic [IMM_W-1:0]     imm;
  } br_fields_t;

  function automatic br_fields_t split_insn(input logic [INSN_W-1:0] w);
    br_fields_t f;
    f.opc   = w[OPC_LO +: OPC_W];
    f.src_a = w[SRC_A_LO +: REG_IDX_W];
    f.src_b = w[SRC_B_LO +: REG_IDX_W];
    f.imm   = w[0 +: IMM_W];
    return f;
  endfunction
endpackage

// File: rtl/dbu_regfile.sv
module dbu_regfile #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int NRD    = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: plain array store, no reset, so it maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous read with write-through for the cycle the value is written.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0) begin
        rdata[p] = '0;
      end else if (we && (waddr == raddr[p])) begin
        rdata[p] = wdata;
      end else begin
        rdata[p] = mem[raddr[p]];
      end
    end
  end
endmodule

// File: rtl/dbu_hazard.sv
module dbu_hazard
  import dbu_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                           is_br,
  input  logic [NSRC-1:0][REG_IDX_W-1:0] src,
  input  stage_kind_e                    ex_kind,
  input  logic [REG_IDX_W-1:0]           ex_dst,
  input  stage_kind_e                    mem_kind,
  input  logic [REG_IDX_W-1:0]           mem_dst,
  output logic [NSRC-1:0]                byp,
  output logic                           stall
);
  logic ex_produces;
  logic mem_is_load;
  logic mem_is_alu;
  logic [NSRC-1:0] wait_ex;
  logic [NSRC-1:0] wait_mem;

  // An ALU result in execute is not yet visible to decode, nor is any load data.
  assign ex_produces = (ex_kind == KIND_ALU) || (ex_kind == KIND_LOAD);
  assign mem_is_load = (mem_kind == KIND_LOAD);
  assign mem_is_alu  = (mem_kind == KIND_ALU);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic live;
    assign live        = (src[s] != '0);
    assign wait_ex[s]  = live && ex_produces && (ex_dst == src[s]);
    assign wait_mem[s] = live && mem_is_load && (mem_dst == src[s]);
    assign byp[s]      = live && mem_is_alu  && (mem_dst == src[s]);
  end

  assign stall = is_br && ((|wait_ex) || (|wait_mem));
endmodule

// File: rtl/dbu_compare.sv
module dbu_compare
  import dbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSRC   = 2
) (
  input  logic                        is_br,
  input  logic [NSRC-1:0][DATA_W-1:0] rf_val,
  input  logic [NSRC-1:0]             byp,
  input  logic [DATA_W-1:0]           mem_result,
  input  logic [IMM_W-1:0]            imm,
  input  logic [DATA_W-1:0]           pc4,
  output logic                        taken,
  output logic [DATA_W-1:0]           target
);
  localparam int EXT_W = DATA_W - IMM_W - 2;

  logic [NSRC-1:0][DATA_W-1:0] opnd;
  logic [DATA_W-1:0]           disp;

  for (genvar s = 0; s < NSRC; s++) begin : g_mux
    assign opnd[s] = byp[s] ? mem_result : rf_val[s];
  end

  assign disp   = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign target = pc4 + disp;
  assign taken  = is_br && (opnd[0] == opnd[1]);
endmodule

// File: rtl/dbu_fetch.sv
module dbu_fetch #(
  parameter int          DATA_W   = 32,
  parameter int          INSN_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              redirect,
  input  logic [DATA_W-1:0] target,
  input  logic [INSN_W-1:0] insn_in,
  output logic [DATA_W-1:0] pc,
  output logic [INSN_W-1:0] ifid_insn,
  output logic [DATA_W-1:0] ifid_pc4
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  logic [DATA_W-1:0] seq_pc;
  assign seq_pc = pc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= RESET_PC[DATA_W-1:0];
      ifid_insn <= '0;
      ifid_pc4  <= '0;
    end else if (!hold) begin
      // The word fetched now is the delay slot when a redirect is pending.
      ifid_insn <= insn_in;
      ifid_pc4  <= seq_pc;
      pc        <= redirect ? target : seq_pc;
    end
  end
endmodule

// File: rtl/decode_branch_unit.sv
module decode_branch_unit
  import dbu_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [5:0]  BR_OPC   = 6'd4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] fetch_pc,
  input  logic [31:0]       fetch_instr,
  input  logic              wb_we,
  input  logic [4:0]        wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [1:0]        ex_kind,
  input  logic [4:0]        ex_dst,
  input  logic [1:0]        mem_kind,
  input  logic [4:0]        mem_dst,
  input  logic [DATA_W-1:0] mem_result,
  output logic [31:0]       ifid_instr,
  output logic [DATA_W-1:0] ifid_pc4,
  output logic              br_stall,
  output logic              br_taken,
  output logic [DATA_W-1:0] br_target
);
  br_fields_t                          fld;
  logic                                is_br;
  logic [NUM_SRC-1:0][REG_IDX_W-1:0]   src;
  logic [NUM_SRC-1:0][DATA_W-1:0]      rf_val;
  logic [NUM_SRC-1:0]                  byp;
  logic                                redirect;

  assign fld    = split_insn(ifid_instr);
  assign is_br  = (fld.opc == BR_OPC);
  assign src[0] = fld.src_a;
  assign src[1] = fld.src_b;

  dbu_regfile #(
    .DATA_W (DATA_W),
    .AW     (REG_IDX_W),
    .NRD    (NUM_SRC)
  ) u_rf (
    .clk   (clk),
    .we    (wb_we),
    .waddr (wb_addr),
    .wdata (wb_data),
    .raddr (src),
    .rdata (rf_val)
  );

  dbu_hazard #(
    .NSRC (NUM_SRC)
  ) u_haz (
    .is_br    (is_br),
    .src      (src),
    .ex_kind  (stage_kind_e'(ex_kind)),
    .ex_dst   (ex_dst),
    .mem_kind (stage_kind_e'(mem_kind)),
    .mem_dst  (mem_dst),
    .byp      (byp),
    .stall    (br_stall)
  );

  dbu_compare #(
    .DATA_W (DATA_W),
    .NSRC   (NUM_SRC)
  ) u_cmp (
    .is_br      (is_br),
    .rf_val     (rf_val),
    .byp        (byp),
    .mem_result (mem_result),
    .imm        (fld.imm),
    .pc4        (ifid_pc4),
    .taken      (br_taken),
    .target     (br_target)
  );

  // A stalled branch never redirects; it is decided again next cycle.
  assign redirect = br_taken && !br_stall;

  dbu_fetch #(
    .DATA_W   (DATA_W),
    .INSN_W   (INSN_W),
    .RESET_PC (RESET_PC)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .hold      (br_stall),
    .redirect  (redirect),
    .target    (br_target),
    .insn_in   (fetch_instr),
    .pc        (fetch_pc),
    .ifid_insn (ifid_instr),
    .ifid_pc4  (ifid_pc4)
  );
endmodule

// File: rtl/decode_branch_unit_sva.sv
module decode_branch_unit_sva #(
  parameter int         DATA_W = 32,
  parameter logic [5:0] BR_OPC = 6'd4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] fetch_pc,
  input logic [31:0]       fetch_instr,
  input logic [31:0]       ifid_instr,
  input logic [DATA_W-1:0] br_target,
  input logic              br_stall,
  input logic              br_taken
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    br_stall |=> fetch_pc == $past(fetch_pc)); // R11

  AST_STALL_HOLDS_IFID: assert property (@(posedge clk) disable iff (rst)
    br_stall |=> $stable(ifid_instr)); // R11

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!br_stall && !br_taken) |=> fetch_pc == $past(fetch_pc) + STEP); // R2

  AST_IFID_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !br_stall |=> ifid_instr == $past(fetch_instr)); // R2

  AST_REDIRECT_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !br_stall) |=> fetch_pc == $past(br_target)); // R12

  AST_TAKEN_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> ifid_instr[31:26] == BR_OPC); // R3

  AST_STALL_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    br_stall |-> ifid_instr[31:26] == BR_OPC); // R7

  AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (ifid_instr[25:21] == 5'd0 && ifid_instr[20:16] == 5'd0) |-> !br_stall); // R10
endmodule

bind decode_branch_unit decode_branch_unit_sva #(
  .DATA_W (DATA_W),
  .BR_OPC (BR_OPC)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .fetch_pc    (fetch_pc),
  .fetch_instr (fetch_instr),
  .ifid_instr  (ifid_instr),
  .br_target   (br_target),
  .br_stall    (br_stall),
  .br_taken    (br_taken)
);

// File: tb/decode_branch_unit_tb.sv
`timescale 1ns/1ps
module decode_branch_unit_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] fetch_pc;
  logic [31:0]   fetch_instr;
  logic          wb_we = 1'b0;
  logic [4:0]    wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic [1:0]    ex_kind = '0;
  logic [4:0]    ex_dst = '0;
  logic [1:0]    mem_kind = '0;
  logic [4:0]    mem_dst = '0;
  logic [DW-1:0] mem_result = '0;
  logic [31:0]   ifid_instr;
  logic [DW-1:0] ifid_pc4;
  logic          br_stall, br_taken;
  logic [DW-1:0] br_target;

  logic [31:0]   imem [64];
  logic [DW-1:0] rv [32];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign fetch_instr = imem[fetch_pc[7:2]];

  decode_branch_unit u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_instr(fetch_instr),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .ex_kind(ex_kind), .ex_dst(ex_dst), .mem_kind(mem_kind), .mem_dst(mem_dst),
    .mem_result(mem_result), .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4),
    .br_stall(br_stall), .br_taken(br_taken), .br_target(br_target)
  );

  function automatic logic [31:0] mk_br(input int a, input int b, input logic [15:0] off);
    return {6'd4, 5'(a), 5'(b), off};
  endfunction

  function automatic logic [DW-1:0] exp_tgt(input logic [DW-1:0] pc4, input logic [15:0] off);
    return pc4 + {{(DW-18){off[15]}}, off, 2'b00};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] w);
    for (int i = 0; i < 64; i++) imem[i] = w;
  endtask

  task automatic fill_seq();
    for (int i = 0; i < 64; i++) imem[i] = {6'd0, 26'(i * 7 + 3)};
  endtask

  task automatic set_pipe(input int ek, input int ed, input int mk, input int md, input logic [DW-1:0] mr);
    ex_kind = 2'(ek); ex_dst = 5'(ed); mem_kind = 2'(mk); mem_dst = 5'(md); mem_result = mr;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rv[0] = '0; rv[1] = 32'h55; rv[2] = 32'h55; rv[3] = 32'hAA;
    for (int i = 4; i < 32; i++) rv[i] = 32'h1000 + 32'(i);
    fill(32'h0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "fetch_pc", fetch_pc, 32'h0);
    chk("R1", "ifid_instr", ifid_instr, 32'h0);
    chk("R1", "stall", 32'(br_stall), 32'h0);
    chk("R1", "taken", 32'(br_taken), 32'h0);
    rst = 1'b0;
    for (int i = 1; i < 32; i++) begin
      @(negedge clk); wb_we = 1'b1; wb_addr = 5'(i); wb_data = rv[i];
    end
    @(negedge clk); wb_we = 1'b0;

    // R2: sequential fetch
    fill_seq();
    do_reset();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R2", "ifid_instr", ifid_instr, imem[c]);
      chk("R2", "ifid_pc4", ifid_pc4, 32'(4 * c + 4));
      chk("R2", "fetch_pc", fetch_pc, 32'(4 * c + 4));
    end

    // R12: taken branch, forward offset, delay slot
    fill_seq(); imem[0] = mk_br(1, 2, 16'd3);
    do_reset();
    @(negedge clk);
    chk("R3", "taken", 32'(br_taken), 32'h1);
    chk("R4", "target", br_target, 32'd16);
    @(negedge clk);
    chk("R12", "delay slot", ifid_instr, imem[1]);
    chk("R12", "fetch_pc", fetch_pc, 32'd16);
    @(negedge clk);
    chk("R12", "target insn", ifid_instr, imem[4]);
    chk("R12", "fetch_pc after", fetch_pc, 32'd20);

    // R12: backward offset
    fill_seq(); imem[0] = mk_br(1, 2, 16'hFFFF);
    do_reset();
    @(negedge clk);
    chk("R4", "neg target", br_target, 32'd0);
    @(negedge clk);
    chk("R12", "neg slot", ifid_instr, imem[1]);
    chk("R12", "neg fetch_pc", fetch_pc, 32'd0);
    @(negedge clk);
    chk("R12", "neg target insn", ifid_instr, imem[0]);

    // R3: not taken
    fill_seq(); imem[0] = mk_br(1, 3, 16'd3);
    do_reset();
    @(negedge clk);
    chk("R3", "unequal taken", 32'(br_taken), 32'h0);
    @(negedge clk);
    chk("R3", "fall through pc", fetch_pc, 32'd8);

    // R13 / R11: stall together with taken
    fill_seq(); imem[0] = mk_br(1, 2, 16'd3);
    set_pipe(1, 1, 0, 0, '0);
    do_reset();
    @(negedge clk);
    chk("R7", "stall", 32'(br_stall), 32'h1);
    chk("R13", "taken while stalled", 32'(br_taken), 32'h1);
    @(negedge clk);
    chk("R13", "pc held", fetch_pc, 32'd4);
    chk("R11", "ifid held", ifid_instr, imem[0]);
    set_pipe(0, 0, 0, 0, '0);
    @(negedge clk);
    chk("R13", "slot after stall", ifid_instr, imem[1]);
    chk("R13", "pc after stall", fetch_pc, 32'd16);

    // R6: write port, write-through, register 0
    fill(mk_br(1, 3, 16'd0));
    @(negedge clk); @(negedge clk);
    chk("R6", "before write", 32'(br_taken), 32'h0);
    @(negedge clk); wb_we = 1'b1; wb_addr = 5'd3; wb_data = 32'h55; #5;
    chk("R6", "write-through", 32'(br_taken), 32'h1);
    @(negedge clk); wb_we = 1'b0; #5;
    chk("R6", "stored", 32'(br_taken), 32'h1);
    @(negedge clk); wb_we = 1'b1; wb_data = 32'hAA; #5;
    chk("R6", "restore through", 32'(br_taken), 32'h0);
    @(negedge clk); wb_we = 1'b0;
    fill(mk_br(0, 1, 16'd0));
    @(negedge clk); @(negedge clk);
    wb_we = 1'b1; wb_addr = 5'd0; wb_data = 32'h55; #5;
    chk("R6", "reg0 no write-through", 32'(br_taken), 32'h0);
    @(negedge clk); wb_we = 1'b0; #5;
    chk("R6", "reg0 write ignored", 32'(br_taken), 32'h0);

    // Sweep: R3 R4 R5 R7 R8 R9 R10
    for (int ra = 0; ra < 4; ra++) begin
      for (int rb = 0; rb < 4; rb++) begin
        logic [15:0] off;
        off = 16'((ra * 4 + rb) * 5) ^ ((rb % 2 == 1) ? 16'hFF00 : 16'h0000);
        set_pipe(0, 0, 0, 0, '0);
        fill(mk_br(ra, rb, off));
        @(negedge clk); @(negedge clk);
        for (int ek = 0; ek < 4; ek++)
          for (int ed = 0; ed < 4; ed++)
            for (int mk = 0; mk < 4; mk++)
              for (int md = 0; md < 4; md++)
                for (int m = 0; m < 2; m++) begin
                  logic [DW-1:0] mr, va, vb;
                  logic hx, hm, ba, bb, se;
                  string tg;
                  mr = (m == 0) ? 32'h55 : 32'hAA;
                  @(negedge clk);
                  set_pipe(ek, ed, mk, md, mr);
                  #5;
                  hx = (ek == 1 || ek == 2) && ed != 0 && (ed == ra || ed == rb);
                  hm = (mk == 2) && md != 0 && (md == ra || md == rb);
                  se = hx || hm;
                  ba = (mk == 1) && md != 0 && md == ra;
                  bb = (mk == 1) && md != 0 && md == rb;
                  va = ba ? mr : rv[ra];
                  vb = bb ? mr : rv[rb];
                  tg = hx ? ((ek == 1) ? "R7" : "R8") : (hm ? "R9" : "R10");
                  chk(tg, "stall", 32'(br_stall), 32'(se));
                  chk((ba || bb) ? "R5" : "R3", "taken", 32'(br_taken), 32'(va == vb));
                  chk("R4", "target", br_target, exp_tgt(ifid_pc4, off));
                end
      end
    end

    // R3: non-branch opcodes neither stall nor take
    set_pipe(0, 0, 0, 0, '0);
    fill({6'd5, 5'd1, 5'd1, 16'd0});
    @(negedge clk); @(negedge clk);
    set_pipe(1, 1, 2, 1, 32'h0); #5;
    chk("R3", "opc5 taken", 32'(br_taken), 32'h0);
    chk("R7", "opc5 stall", 32'(br_stall), 32'h0);
    set_pipe(0, 0, 0, 0, '0);
    fill({6'd0, 5'd2, 5'd2, 16'd0});
    @(negedge clk); @(negedge clk); #5;
    chk("R3", "opc0 taken", 32'(br_taken), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule